// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block performs one 8-bit arithmetic, logic, shift or rotate operation per cycle. It feeds a registered eight-bit condition flag word. The datapath is purely combinational. `result_o` follows `a_i`, `b_i`, `op_i` and the stored carry within the same cycle. A destination write strobe tells the surrounding datapath whether the result should be stored. The flag word is updated at the clock edge when `valid_i` is high.

Two operations, compare and bit test, only form flags and never raise the write strobe. A separate pair of inputs sets or clears the interrupt mask bit in the flag word, independently of any operation. Instruction decode, operand fetch and wide index comparison are handled outside the block.

Top module: `byte_alu_cc`

## Requirements
- R1: After reset `flags_o` is 0xD0. The fixed bit layout is: bit 0 carry C, bit 1 overflow V, bit 2 zero Z, bit 3 negative N, bit 4 interrupt mask I, bit 5 half carry H, bits 6 and 7 constant 1.
- R2: `op_i` encodings are 0 add, 1 add-with-carry, 2 subtract, 3 compare, 4 AND, 5 OR, 6 XOR, 7 bit test, 8 complement, 9 increment, 10 decrement, 11 logical shift right, 12 shift left, 13 arithmetic shift right, 14 rotate left, 15 rotate right. `result_o` is the combinational result of the selected operation on `a_i` (and `b_i` where used) in the same cycle.
- R3: Add computes a+b and add-with-carry computes a+b+C. Both set H to the carry out of bit 3 and C to the carry out of bit 7. They set V on signed overflow (0x4F+0x40 gives 0x8F with V=1; 0xB1+0xC0 gives 0x71 with V=1 and C=1).
- R4: Subtract and compare compute a-b. C is set when b is unsigned-greater than a. V is set when the signed difference leaves -128..127. H is left unchanged. Compare writes no result (0xE3-0xA0 gives 0x43).
- R5: AND, OR, XOR and bit test clear V and leave C and H unchanged. Bit test writes no result.
- R6: Complement produces the bitwise inverse of a, sets C to 1 and clears V.
- R7: Increment and decrement leave C and H unchanged. V is set only when a is 0x7F for increment, or 0x80 for decrement.
- R8: All shifts and rotates leave H unchanged and set V to N XOR C of the new flags. The five operations move bits as follows:
  - Logical shift right moves bit 0 to C and fills bit 7 with 0.
  - Shift left moves bit 7 to C and fills bit 0 with 0.
  - Arithmetic shift right keeps bit 7 and moves bit 0 to C.
  - Rotate left moves the old C into bit 0 and bit 7 into C.
  - Rotate right moves the old C into bit 7 and bit 0 into C.
- R9: `wr_en_o` is high exactly when `valid_i` is high and the operation is neither compare nor bit test.
- R10: With `valid_i` high, N becomes result bit 7 and Z becomes 1 when the result is 0x00, at the next clock edge. With `valid_i` low, C, V, Z, N and H keep their values. No operation alters I.
- R11: `mask_set_i` sets I at the next edge and `mask_clr_i` clears it. Set wins when both are high.
- R12: Bits 7 and 6 of `flags_o` read 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the operation this cycle |
| op_i | input | 4 | Operation select |
| a_i | input | 8 | Register operand |
| b_i | input | 8 | Second operand |
| mask_set_i | input | 1 | Set interrupt mask |
| mask_clr_i | input | 1 | Clear interrupt mask |
| result_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Destination write strobe |
| flags_o | output | 8 | Registered condition flags |

## Verification
A corrupted flag bit shows on `flags_o` one edge after the operation that wrote it. A stale carry is exposed in the same cycle on `result_o` by the next add-with-carry or rotate, since both read the stored carry. A fault in the flag hold path shows only after an idle cycle or a flag-preserving operation, so the stimulus interleaves idle cycles with increments and logic operations. Each result and strobe is compared in the cycle it is driven, and each flag word right after the following edge.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DW = 8;
  localparam int FW = 8;
  localparam int NW = 4;  // nibble width for half carry

  localparam int F_C = 0;
  localparam int F_V = 1;
  localparam int F_Z = 2;
  localparam int F_N = 3;
  localparam int F_I = 4;
  localparam int F_H = 5;

  localparam logic [FW-1:0] FLAGS_RST = 8'hD0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_CMP = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_BIT = 4'd7,
    OP_COM = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_LSR = 4'd11,
    OP_ASL = 4'd12, OP_ASR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
    logic          h;
    logic          upd_c;
    logic          upd_v;
    logic          upd_h;
  } unit_out_t;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output unit_out_t     out_o
);
  logic [DW-1:0] opnd;
  logic          ci;
  logic [DW:0]   sum;
  logic [NW:0]   nib;
  logic          is_sub;

  always_comb begin
    opnd   = b_i;
    ci     = 1'b0;
    is_sub = 1'b0;
    case (op_i)
      OP_ADC:         ci = cin_i;
      OP_SUB, OP_CMP: begin opnd = ~b_i; ci = 1'b1; is_sub = 1'b1; end
      OP_INC:         begin opnd = '0; ci = 1'b1; end
      OP_DEC:         opnd = '1;
      default:        ;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, opnd} + {{DW{1'b0}}, ci};
  assign nib = {1'b0, a_i[NW-1:0]} + {1'b0, opnd[NW-1:0]} + {{NW{1'b0}}, ci};

  always_comb begin
    out_o.res   = sum[DW-1:0];
    // signed overflow: like-signed inputs give an unlike-signed result
    out_o.v     = (a_i[DW-1] == opnd[DW-1]) && (sum[DW-1] != a_i[DW-1]);
    out_o.c     = is_sub ? ~sum[DW] : sum[DW];
    out_o.h     = nib[NW];
    out_o.upd_v = 1'b1;
    out_o.upd_c = (op_i != OP_INC) && (op_i != OP_DEC);
    out_o.upd_h = (op_i == OP_ADD) || (op_i == OP_ADC);
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output unit_out_t     out_o
);
  always_comb begin
    case (op_i)
      OP_OR:   out_o.res = a_i | b_i;
      OP_XOR:  out_o.res = a_i ^ b_i;
      OP_COM:  out_o.res = ~a_i;
      default: out_o.res = a_i & b_i;
    endcase
    out_o.c     = 1'b1;
    out_o.v     = 1'b0;
    out_o.h     = 1'b0;
    out_o.upd_c = (op_i == OP_COM);
    out_o.upd_v = 1'b1;
    out_o.upd_h = 1'b0;
  end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
  import byte_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic          cin_i,
  output unit_out_t     out_o
);
  logic          fill;
  logic          left;
  logic [DW-1:0] res;
  logic          c;

  always_comb begin
    left = (op_i == OP_ASL) || (op_i == OP_ROL);
    case (op_i)
      OP_ASR:         fill = a_i[DW-1];
      OP_ROL, OP_ROR: fill = cin_i;
      default:        fill = 1'b0;
    endcase
    if (left) begin
      res = {a_i[DW-2:0], fill};
      c   = a_i[DW-1];
    end else begin
      res = {fill, a_i[DW-1:1]};
      c   = a_i[0];
    end
    out_o.res   = res;
    out_o.c     = c;
    out_o.v     = res[DW-1] ^ c;
    out_o.h     = 1'b0;
    out_o.upd_c = 1'b1;
    out_o.upd_v = 1'b1;
    out_o.upd_h = 1'b0;
  end
endmodule

// File: rtl/byte_alu_cc.sv
module byte_alu_cc
  import byte_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          mask_set_i,
  input  logic          mask_clr_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic [FW-1:0] flags_o
);
  alu_op_e       op;
  unit_out_t     ar_out, lg_out, sh_out, sel;
  logic [FW-1:0] flags_q, flags_d;

  assign op = alu_op_e'(op_i);

  byte_alu_arith u_arith (.op_i(op), .a_i(a_i), .b_i(b_i), .cin_i(flags_q[F_C]), .out_o(ar_out));
  byte_alu_logic u_logic (.op_i(op), .a_i(a_i), .b_i(b_i), .out_o(lg_out));
  byte_alu_shift u_shift (.op_i(op), .a_i(a_i), .cin_i(flags_q[F_C]), .out_o(sh_out));

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_BIT, OP_COM:         sel = lg_out;
      OP_LSR, OP_ASL, OP_ASR, OP_ROL, OP_ROR:        sel = sh_out;
      default:                                       sel = ar_out;
    endcase
  end

  assign result_o = sel.res;
  assign wr_en_o  = valid_i && (op != OP_CMP) && (op != OP_BIT);

  always_comb begin
    flags_d = flags_q;
    if (valid_i) begin
      if (sel.upd_c) flags_d[F_C] = sel.c;
      if (sel.upd_v) flags_d[F_V] = sel.v;
      if (sel.upd_h) flags_d[F_H] = sel.h;
      flags_d[F_Z] = (sel.res == '0);
      flags_d[F_N] = sel.res[DW-1];
    end
    if (mask_set_i)      flags_d[F_I] = 1'b1;
    else if (mask_clr_i) flags_d[F_I] = 1'b0;
    flags_d[FW-1:F_H+1] = '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= FLAGS_RST;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !mask_set_i && !mask_clr_i |=> $stable(flags_o));
  a_r11_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i |=> flags_o[F_I]);
  a_r11_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_clr_i && !mask_set_i |=> !flags_o[F_I]);
  a_r9_no_write_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_BIT) |-> !wr_en_o);
  a_r7_keep_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[F_C] == $past(flags_o[F_C]));
  a_r5_clear_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= OP_AND && op_i <= OP_COM |=> !flags_o[F_V]);
  a_r10_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[F_Z] == ($past(result_o) == '0));
  a_r8_shift_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= OP_LSR |=> flags_o[F_V] == (flags_o[F_N] ^ flags_o[F_C]));
  a_r12_fixed_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[FW-1:FW-2] == 2'b11);
endmodule

// File: tb/byte_alu_cc_test.sv
`timescale 1ns/1ps
module byte_alu_cc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       mset = 1'b0, mclr = 1'b0;
  logic [7:0] result;
  logic       wr_en;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mflags;

  always #4 clk = ~clk;

  byte_alu_cc uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .mask_set_i(mset), .mask_clr_i(mclr), .result_o(result), .wr_en_o(wr_en), .flags_o(flags)
  );

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:             return "R3";
      4'd2, 4'd3:             return "R4";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5";
      4'd8:                   return "R6";
      4'd9, 4'd10:            return "R7";
      default:                return "R8";
    endcase
  endfunction

  function automatic int sx(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  // returns {wr, result, flags-after-op} ignoring mask inputs and valid
  function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] f);
    int s; int sv; logic [7:0] r; logic [7:0] nf; logic cin; logic w;
    nf = f; cin = f[0]; w = 1'b1; r = '0;
    case (o)
      4'd0, 4'd1: begin
        s = int'(x) + int'(y) + ((o == 4'd1) ? int'(cin) : 0);
        sv = sx(x) + sx(y) + ((o == 4'd1) ? int'(cin) : 0);
        r = s[7:0];
        nf[5] = ((int'(x[3:0]) + int'(y[3:0]) + ((o == 4'd1) ? int'(cin) : 0)) > 15);
        nf[0] = (s > 255);
        nf[1] = (sv > 127) || (sv < -128);
      end
      4'd2, 4'd3: begin
        s = int'(x) - int'(y); sv = sx(x) - sx(y);
        r = s[7:0];
        nf[0] = (y > x);
        nf[1] = (sv > 127) || (sv < -128);
        w = (o == 4'd2);
      end
      4'd4: begin r = x & y; nf[1] = 1'b0; end
      4'd5: begin r = x | y; nf[1] = 1'b0; end
      4'd6: begin r = x ^ y; nf[1] = 1'b0; end
      4'd7: begin r = x & y; nf[1] = 1'b0; w = 1'b0; end
      4'd8: begin r = ~x; nf[1] = 1'b0; nf[0] = 1'b1; end
      4'd9: begin r = x + 8'd1; nf[1] = (x == 8'h7F); end
      4'd10: begin r = x - 8'd1; nf[1] = (x == 8'h80); end
      4'd11: begin r = x >> 1; nf[0] = x[0]; end
      4'd12: begin r = x << 1; nf[0] = x[7]; end
      4'd13: begin r = {x[7], x[7:1]}; nf[0] = x[0]; end
      4'd14: begin r = {x[6:0], cin}; nf[0] = x[7]; end
      default: begin r = {cin, x[7:1]}; nf[0] = x[0]; end
    endcase
    nf[2] = (r == 8'h00);
    nf[3] = r[7];
    if (o >= 4'd11) nf[1] = nf[3] ^ nf[0];
    return {w, r, nf};
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit vld, input logic [3:0] o, input logic [7:0] x,
                      input logic [7:0] y, input bit ms, input bit mc);
    logic [16:0] m; logic [7:0] ef;
    @(negedge clk);
    valid = vld; op = o; a = x; b = y; mset = ms; mclr = mc;
    #1;
    m = model(o, x, y, mflags);
    check8({"R2 ", tag_of(o), " result"}, result, m[15:8]);
    check8("R9 write strobe", {7'd0, wr_en}, {7'd0, vld & m[16]});
    ef = vld ? m[7:0] : mflags;
    if (ms) ef[4] = 1'b1;
    else if (mc) ef[4] = 1'b0;
    ef[7:6] = 2'b11;
    @(posedge clk); #2;
    if (!vld)          check8("R10 hold", flags, ef);
    else if (ms || mc) check8({"R11 ", tag_of(o), " flags"}, flags, ef);
    else               check8({tag_of(o), " flags"}, flags, ef);
    check8("R12 fixed bits", {6'd0, flags[7:6]}, 8'd3);
    mflags = ef;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    check8("R1 reset flags", flags, 8'hD0);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1 flags after release", flags, 8'hD0);
    mflags = 8'hD0;

    step(1, 4'd0, 8'h4F, 8'h40, 0, 0);   // R3 positive overflow
    step(1, 4'd0, 8'hB1, 8'hC0, 0, 0);   // R3 negative overflow with carry
    step(1, 4'd8, 8'h00, 8'h00, 0, 0);   // R6 sets carry
    step(1, 4'd1, 8'h3A, 8'h7C, 0, 0);   // R3 add with carry
    step(1, 4'd2, 8'hE3, 8'hA0, 0, 0);   // R4 subtract
    step(1, 4'd3, 8'h37, 8'h37, 0, 0);   // R4 equal compare
    step(1, 4'd3, 8'h10, 8'h37, 0, 0);   // R4 operand larger
    step(1, 4'd3, 8'h50, 8'h37, 0, 0);   // R4 operand smaller
    step(1, 4'd7, 8'h3A, 8'h05, 0, 0);   // R5 bit test, no write
    step(1, 4'd11, 8'h7A, 8'h00, 0, 0);  // R8 logical right
    step(1, 4'd12, 8'h7A, 8'h00, 0, 0);  // R8 shift left
    step(1, 4'd8, 8'h3A, 8'h00, 0, 0);   // R6
    step(1, 4'd14, 8'h7A, 8'h00, 0, 0);  // R8 rotate left with C=1
    step(1, 4'd13, 8'h81, 8'h00, 0, 0);  // R8 arithmetic right
    step(1, 4'd15, 8'h01, 8'h00, 0, 0);  // R8 rotate right
    step(1, 4'd9, 8'h7F, 8'h00, 0, 0);   // R7 inc overflow
    step(1, 4'd10, 8'h80, 8'h00, 0, 0);  // R7 dec overflow
    step(1, 4'd10, 8'h01, 8'h00, 0, 0);  // R7 dec to zero
    step(0, 4'd0, 8'hFF, 8'hFF, 0, 0);   // R10 idle hold
    step(0, 4'd0, 8'h00, 8'h00, 0, 1);   // R11 clear mask
    step(1, 4'd5, 8'h00, 8'h00, 1, 1);   // R11 set wins
    step(1, 4'd9, 8'hFF, 8'h00, 0, 1);   // R10 op leaves I, mask clear

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[3:0] != 4'd0, r[7:4], r[15:8], r[23:16], r[27:24] == 4'd0, r[31:28] == 4'd1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule